// File: doc/BRIEF.md
# Interrupt Flag and Vector Controller

This block collects interrupt events for a small 8-bit microcontroller core. Each event sets a sticky flag. The flags sit in two groups. The core group holds the external pin, pin-change and timer0 overflow flags. The peripheral group holds the converter, comparator, timer1 overflow, timer2 match and capture/compare flags. Every flag has an enable. A peripheral-group enable and a global enable sit above the individual enables. When an enabled flag is set and interrupts are globally on, the block asks the core to vector to address 0x0004 and to push its return address. In the same action it turns the global enable off. A return strobe from the core turns the global enable back on.

The external pin passes through a two-flop synchronizer. Its active edge is selectable. A pin that is configured as analog can never raise its flag. While the core sleeps, an enabled pending flag raises a wake request instead of a vector. Software reads and writes the flag and enable bits as three registers.

Top module: `intc_flags`

## Requirements
- R1: After reset, every flag, every enable and the global enable read 0, and `vec_take` and `wake_req` are 0.
- R2: An event input sets its flag at the next clock edge, whatever its own enable, the group enable or the global enable hold. The flag then stays set until software writes it to 0.
- R3: A software write loads the written flag values. When an event arrives in the same cycle as a write of 0 to its flag, the event wins and the flag stays set.
- R4: `vec_take` is high when the global enable is 1, the core is awake, and at least one of these holds: a core flag is set together with its enable, or the peripheral-group enable (control bit 6) is 1 and a peripheral flag is set together with its enable. While `vec_take` is high, `push_req` is also high and `vec_addr` equals 0x0004.
- R5: In the cycle after `vec_take`, the global enable (control bit 7) reads 0.
- R6: A `reti` strobe with no vector taken in that cycle sets the global enable at the next edge.
- R7: The external flag (control bit 2) is set three clock edges after the pin changes. It is set on a 0 to 1 change when `edge_rise` is 1, and on a 1 to 0 change when `edge_rise` is 0. A change in the other direction leaves the flag alone.
- R8: While `pin_analog` is 1, no pin change sets the external flag.
- R9: A control write with bit 7 equal to 0 blocks `vec_take` in that same cycle. The pending flag stays set and is serviced once the global enable is set again.
- R10: While `sleeping` is 1, `vec_take` is 0, and `wake_req` is high when any enabled flag is set. For this, the peripheral group counts only when its group enable is on, and the global enable is not needed.
- R11: A flag that software leaves set causes a new vector as soon as the global enable returns to 1.

Register layouts. The control register bits are: 7 global enable, 6 peripheral-group enable, 5 external enable, 4 pin-change enable, 3 timer0 enable, 2 external flag, 1 pin-change flag, 0 timer0 flag. The peripheral enable and flag registers use the same bit order: 0 converter, 1 comparator, 2 timer1, 3 timer2, 4 capture/compare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin | input | 1 | External interrupt pin (asynchronous) |
| pin_analog | input | 1 | Pin is configured as analog |
| edge_rise | input | 1 | 1: rising edge is active, 0: falling edge is active |
| chg_evt | input | 1 | Pin-change event pulse |
| t0_evt | input | 1 | Timer0 overflow pulse |
| periph_evt | input | 5 | Peripheral event pulses |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| pen_we | input | 1 | Peripheral enable write strobe |
| pen_wdata | input | 5 | Peripheral enable write data |
| pflg_we | input | 1 | Peripheral flag write strobe |
| pflg_wdata | input | 5 | Peripheral flag write data |
| reti | input | 1 | Return-from-interrupt strobe |
| sleeping | input | 1 | Core is asleep |
| ctl_q | output | 8 | Control register readback |
| pen_q | output | 5 | Peripheral enable readback |
| pflg_q | output | 5 | Peripheral flag readback |
| vec_take | output | 1 | Vector request to the core |
| push_req | output | 1 | Return-address push request |
| vec_addr | output | 13 | Vector address |
| wake_req | output | 1 | Wake request during sleep |

## Verification
Some rules are checked on every cycle. The global enable must drop after each vector. A return with no vector must raise it. No vector may appear during sleep, or in a cycle that writes the global enable to 0. Peripheral flags must stay sticky, and a peripheral event must always land in its flag. Other behaviours come out only through the bench's scenarios. These are the exact three-edge latency of the pin synchronizer, the choice of edge polarity, the analog mask, the event winning over a clearing write, and a pending flag that is held back by a disable write and then serviced after the return.

// File: rtl/intc_flags.sv
module intc_flags #(
  parameter int NPER = 5,
  parameter int AW = 13,
  parameter logic [AW-1:0] VEC = 13'h0004
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ext_pin,
  input  logic            pin_analog,
  input  logic            edge_rise,
  input  logic            chg_evt,
  input  logic            t0_evt,
  input  logic [NPER-1:0] periph_evt,
  input  logic            ctl_we,
  input  logic [7:0]      ctl_wdata,
  input  logic            pen_we,
  input  logic [NPER-1:0] pen_wdata,
  input  logic            pflg_we,
  input  logic [NPER-1:0] pflg_wdata,
  input  logic            reti,
  input  logic            sleeping,
  output logic [7:0]      ctl_q,
  output logic [NPER-1:0] pen_q,
  output logic [NPER-1:0] pflg_q,
  output logic            vec_take,
  output logic            push_req,
  output logic [AW-1:0]   vec_addr,
  output logic            wake_req
);
  logic gie, pe;
  logic [2:0] cen, cfl;
  logic [NPER-1:0] pen_r, pfl;
  logic s1, s2, sp;

  wire ext_evt  = ~pin_analog & (edge_rise ? (s2 & ~sp) : (~s2 & sp));
  wire [2:0] cevt = {ext_evt, chg_evt, t0_evt};
  wire any_req  = (|(cen & cfl)) | (pe & (|(pen_r & pfl)));
  wire gie_off_wr = ctl_we & ~ctl_wdata[7];

  assign vec_take = gie & any_req & ~sleeping & ~gie_off_wr;
  assign push_req = vec_take;
  assign vec_addr = vec_take ? VEC : '0;
  assign wake_req = sleeping & any_req;
  assign ctl_q    = {gie, pe, cen, cfl};
  assign pen_q    = pen_r;
  assign pflg_q   = pfl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      sp <= 1'b0;
    end else begin
      s1 <= ext_pin;
      s2 <= s1;
      sp <= s2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie <= 1'b0;
      pe  <= 1'b0;
      cen <= '0;
      cfl <= '0;
    end else begin
      if (vec_take)    gie <= 1'b0;
      else if (reti)   gie <= 1'b1;
      else if (ctl_we) gie <= ctl_wdata[7];
      if (ctl_we) begin
        pe  <= ctl_wdata[6];
        cen <= ctl_wdata[5:3];
      end
      cfl <= (ctl_we ? ctl_wdata[2:0] : cfl) | cevt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pen_r <= '0;
      pfl   <= '0;
    end else begin
      if (pen_we) pen_r <= pen_wdata;
      pfl <= (pflg_we ? pflg_wdata : pfl) | periph_evt;
    end
  end
endmodule

// File: rtl/intc_flags_chk.sv
module intc_flags_chk #(parameter int NPER = 5, parameter int AW = 13) (
  input logic            clk,
  input logic            rst_n,
  input logic [NPER-1:0] periph_evt,
  input logic            ctl_we,
  input logic [7:0]      ctl_wdata,
  input logic            pflg_we,
  input logic            reti,
  input logic            sleeping,
  input logic [7:0]      ctl_q,
  input logic [NPER-1:0] pflg_q,
  input logic            vec_take,
  input logic            push_req,
  input logic [AW-1:0]   vec_addr
);
  a_r5_take_clears_gie: assert property (@(posedge clk) disable iff (!rst_n)
    vec_take |=> !ctl_q[7]);
  a_r6_reti_sets_gie: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && !vec_take) |=> ctl_q[7]);
  a_r4_vector_form: assert property (@(posedge clk) disable iff (!rst_n)
    vec_take |-> (ctl_q[7] && push_req && vec_addr == 13'h0004));
  a_r10_no_take_asleep: assert property (@(posedge clk) disable iff (!rst_n)
    sleeping |-> !vec_take);
  a_r9_disable_write_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && !ctl_wdata[7]) |-> !vec_take);
  a_r2_pflags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !pflg_we |=> ((pflg_q & $past(pflg_q)) == $past(pflg_q)));
  a_r3_event_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (periph_evt != '0) |=> ((pflg_q & $past(periph_evt)) == $past(periph_evt)));
endmodule

bind intc_flags intc_flags_chk #(.NPER(NPER), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .periph_evt(periph_evt), .ctl_we(ctl_we),
  .ctl_wdata(ctl_wdata), .pflg_we(pflg_we), .reti(reti), .sleeping(sleeping),
  .ctl_q(ctl_q), .pflg_q(pflg_q), .vec_take(vec_take), .push_req(push_req),
  .vec_addr(vec_addr)
);

// File: tb/intc_flags_bench.sv
module intc_flags_bench;
  logic clk = 0, rst_n = 0;
  logic ext_pin = 0, pin_analog = 0, edge_rise = 0, chg_evt = 0, t0_evt = 0;
  logic [4:0] periph_evt = 0;
  logic ctl_we = 0; logic [7:0] ctl_wdata = 0;
  logic pen_we = 0; logic [4:0] pen_wdata = 0;
  logic pflg_we = 0; logic [4:0] pflg_wdata = 0;
  logic reti = 0, sleeping = 0;
  logic [7:0] ctl_q; logic [4:0] pen_q, pflg_q;
  logic vec_take, push_req, wake_req; logic [12:0] vec_addr;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  intc_flags u_intc_flags (.*);

  // reference state
  bit m_gie, m_pe; bit [2:0] m_en, m_fl; bit [4:0] m_pen, m_pf;
  bit hist[$];

  function automatic bit m_any();
    return (|(m_en & m_fl)) || (m_pe && (|(m_pen & m_pf)));
  endfunction
  function automatic bit m_vec();
    return m_gie && m_any() && !sleeping && !(ctl_we && !ctl_wdata[7]);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk(ctl_q == {m_gie, m_pe, m_en, m_fl}, "R2/R5 control readback", ctl_q, {m_gie, m_pe, m_en, m_fl});
    chk(pflg_q == m_pf, "R2 peripheral flags", pflg_q, m_pf);
    chk(pen_q == m_pen, "R3 peripheral enables", pen_q, m_pen);
    chk(vec_take == m_vec(), "R4 vec_take", vec_take, m_vec());
    chk(push_req == m_vec(), "R4 push_req", push_req, m_vec());
    chk(vec_addr == (m_vec() ? 13'h4 : 13'h0), "R4 vec_addr", vec_addr, m_vec() ? 4 : 0);
    chk(wake_req == (sleeping && m_any()), "R10 wake_req", wake_req, sleeping && m_any());
  endtask

  task automatic model_step();
    bit v, e;
    v = m_vec();
    e = 0;
    if (hist.size() >= 3 && !pin_analog)
      e = edge_rise ? (hist[1] && !hist[2]) : (!hist[1] && hist[2]);
    if (v) m_gie = 0;
    else if (reti) m_gie = 1;
    else if (ctl_we) m_gie = ctl_wdata[7];
    if (ctl_we) begin m_pe = ctl_wdata[6]; m_en = ctl_wdata[5:3]; end
    m_fl = (ctl_we ? ctl_wdata[2:0] : m_fl) | {e, chg_evt, t0_evt};
    if (pen_we) m_pen = pen_wdata;
    m_pf = (pflg_we ? pflg_wdata : m_pf) | periph_evt;
    hist.push_front(ext_pin);
    if (hist.size() > 3) void'(hist.pop_back());
  endtask

  task automatic cyc();
    #1 compare_all();
    @(posedge clk);
    model_step();
    @(negedge clk);
    ctl_we = 0; pen_we = 0; pflg_we = 0; reti = 0;
    chg_evt = 0; t0_evt = 0; periph_evt = 0;
  endtask

  task automatic ncyc(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic wr_ctl(input logic [7:0] d);
    ctl_we = 1; ctl_wdata = d; cyc();
  endtask

  initial begin
    #400000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    hist = {0, 0, 0};
    repeat (3) @(negedge clk);
    #1;
    chk(ctl_q == 0 && pen_q == 0 && pflg_q == 0, "R1 reset registers", ctl_q, 0);
    chk(!vec_take && !wake_req, "R1 reset outputs", vec_take, 0);
    @(negedge clk); rst_n = 1;
    ncyc(2);

    t0_evt = 1; cyc();
    chk(ctl_q[0] == 1, "R2 flag set with enables off", ctl_q[0], 1);
    wr_ctl(8'h89);
    #1 chk(vec_take == 1 && vec_addr == 13'h4, "R4 vector on enabled flag", vec_take, 1);
    cyc();
    chk(ctl_q[7] == 0, "R5 global enable cleared", ctl_q[7], 0);
    reti = 1; cyc();
    chk(ctl_q[7] == 1, "R6 reti sets global enable", ctl_q[7], 1);
    #1 chk(vec_take == 1, "R11 leftover flag retakes", vec_take, 1);
    cyc();
    wr_ctl(8'h08);

    chg_evt = 1; ctl_we = 1; ctl_wdata = 8'h08; cyc();
    chk(ctl_q[1] == 1, "R3 event beats clearing write", ctl_q[1], 1);
    wr_ctl(8'h08);
    chk(ctl_q[1] == 0, "R3 write clears flag", ctl_q[1], 0);

    edge_rise = 1; wr_ctl(8'h20);
    ext_pin = 1; ncyc(2);
    chk(ctl_q[2] == 0, "R7 not yet after two edges", ctl_q[2], 0);
    cyc();
    chk(ctl_q[2] == 1, "R7 rising edge after three edges", ctl_q[2], 1);
    wr_ctl(8'h20);
    ext_pin = 0; ncyc(4);
    chk(ctl_q[2] == 0, "R7 falling ignored in rise mode", ctl_q[2], 0);
    edge_rise = 0; ext_pin = 1; ncyc(4);
    chk(ctl_q[2] == 0, "R7 rising ignored in fall mode", ctl_q[2], 0);
    ext_pin = 0; ncyc(4);
    chk(ctl_q[2] == 1, "R7 falling edge sets flag", ctl_q[2], 1);
    wr_ctl(8'h20);

    pin_analog = 1; ext_pin = 1; ncyc(4); ext_pin = 0; ncyc(4);
    chk(ctl_q[2] == 0, "R8 analog pin masked", ctl_q[2], 0);
    pin_analog = 0; ncyc(2);

    pen_we = 1; pen_wdata = 5'b00100; cyc();
    periph_evt = 5'b00100; cyc();
    chk(pflg_q == 5'b00100, "R2 peripheral flag", pflg_q, 4);
    wr_ctl(8'h80);
    #1 chk(vec_take == 0, "R4 peripheral group gated", vec_take, 0);
    wr_ctl(8'hC0);
    #1 chk(vec_take == 1, "R4 peripheral vector", vec_take, 1);
    cyc();
    pflg_we = 1; pflg_wdata = 0; cyc();

    sleeping = 1; wr_ctl(8'hA0);
    edge_rise = 1; ext_pin = 1; ncyc(4);
    chk(wake_req == 1 && vec_take == 0, "R10 wake while sleeping", wake_req, 1);
    sleeping = 0; ctl_we = 1; ctl_wdata = 8'h24;
    #1 chk(vec_take == 0, "R9 disable write blocks vector", vec_take, 0);
    cyc();
    chk(ctl_q[2] == 1 && ctl_q[7] == 0, "R9 flag held pending", ctl_q, 8'h24);
    reti = 1; cyc();
    #1 chk(vec_take == 1, "R9 pending serviced after reti", vec_take, 1);
    ncyc(3);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule